// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block turns a single asynchronous serial line into parallel characters. A free-running enable at sixteen times the baud rate, supplied from outside, paces all of its timing. The raw line first passes through a two-stage synchronizer. A falling edge then starts a candidate frame, and that frame is only accepted if the line is still low at the middle of the start bit. Once a frame is accepted, the data bits arrive least significant first, followed by an optional parity bit and then the stop bit. Each bit is sampled at its midpoint.

Static configuration inputs set four things: the character length (5 to 8 bits), the parity mode (none, even or odd), the stop length (1, 1.5 or 2 bits) and where finished characters go. When a character completes, the block drives the data and three status flags (parity error, framing error, break) together with a one-cycle valid strobe. It also pulses exactly one of two load strobes, one for a single holding register and one for a receive FIFO, chosen by the routing input. Everything is synchronous to the rising edge of one clock.

Top module: `uart_rx_core`

## Requirements
- R1: With the length code set to 3, a frame carrying eight data bits least significant bit first appears on `char_data`, and `char_valid` is high for exactly one clock per character.
- R2: The length code `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. For shorter characters the unused upper bits of `char_data` read zero.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_odd`=0 means even parity (data plus parity holds an even number of ones) and 1 means odd parity. `char_perr` is 1 exactly when the received bit disagrees. When parity is disabled, `char_perr` is 0.
- R4: If the first stop bit samples low and the character is not a break, the character is still delivered, with `char_ferr`=1 and `char_brk`=0.
- R5: A low pulse shorter than half a bit time is a false start. The receiver returns to idle without producing a character, and a later valid frame is received normally.
- R6: If the line stays low across start, data, parity and stop, exactly one character is emitted with data 0, `char_brk`=1 and `char_ferr`=1. No further character is produced until the line returns high, and normal reception resumes afterwards.
- R7: With `cfg_fifo_mode`=1 each character pulses `fifo_push` and not `hold_load`. With 0 it pulses `hold_load` and not `fifo_push`. The strobe is coincident with `char_valid`.
- R8: `cfg_stop` values 0, 1 and 2 (3 behaves as 2) select 1, 1.5 and 2 stop bits. After the first stop bit is sampled, the receiver ignores falling edges for the rest of the configured stop time: 0, 16 or 24 sixteenth-bit ticks. Frames sent back to back with the configured stop length are all received.
- R9: After reset `char_valid`, `hold_load`, `fifo_push`, the flags and `char_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-clock enable at 16x the baud rate |
| rx_in | input | 1 | Raw serial line, idle high |
| cfg_len | input | 2 | Character length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop | input | 2 | Stop length: 0 one, 1 one and a half, 2/3 two |
| cfg_fifo_mode | input | 1 | 1 routes characters to the FIFO strobe, 0 to the holding strobe |
| char_data | output | 8 | Received character, right-aligned |
| char_valid | output | 1 | One-clock pulse per completed character |
| hold_load | output | 1 | Load pulse for the holding register |
| fifo_push | output | 1 | Push pulse for the receive FIFO |
| char_perr | output | 1 | Parity error of the last character |
| char_ferr | output | 1 | Framing error of the last character |
| char_brk | output | 1 | Break condition on the last character |

## Verification
The bit counter and the state register are the internal state most likely to go wrong. Either fault shows up within a single frame: as shifted or wrongly aligned data, a missing or duplicated `char_valid`, or flags set on a clean frame. A receiver that fails to leave the break-wait or stop-tail state shows up only on the following frame, as a lost character. The bench therefore always sends a clean frame after every break, false-start and tail scenario. A wrong sample point only shows when the line changes near a bit boundary, so the patterns alternate bit values.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int SYNC_STAGES = 2,
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_in,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  input  logic       cfg_fifo_mode,
  output logic [7:0] char_data,
  output logic       char_valid,
  output logic       hold_load,
  output logic       fifo_push,
  output logic       char_perr,
  output logic       char_ferr,
  output logic       char_brk
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int TW   = CW + 1;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_START = 3'd1, S_DATA = 3'd2, S_PAR = 3'd3,
    S_STOP = 3'd4, S_TAIL = 3'd5, S_BRKW = 3'd6
  } st_t;

  st_t st;
  logic [SYNC_STAGES-1:0] sync_q;
  logic          rx_s, rx_d, fall;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tcnt, tail_len;
  logic [2:0]    bidx, last_idx;
  logic [7:0]    sh, data_al;
  logic          pbit, seen_hi, mid, stop_low, is_brk, par_bad;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};

  assign rx_s     = sync_q[SYNC_STAGES-1];
  assign fall     = rx_d & ~rx_s;
  assign mid      = tick16 && (cnt == CW'(OVS - 1));
  assign last_idx = {1'b0, cfg_len} + 3'd4;
  assign data_al  = sh >> (2'd3 - cfg_len);
  assign stop_low = ~rx_s;
  assign is_brk   = stop_low & ~seen_hi;
  assign par_bad  = cfg_par_en & (pbit ^ (^data_al) ^ cfg_par_odd);
  assign tail_len = (cfg_stop == 2'd0) ? TW'(0) :
                    (cfg_stop == 2'd1) ? TW'(OVS) : TW'(OVS + HALF);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_IDLE;
      rx_d       <= 1'b1;
      cnt        <= '0;
      tcnt       <= '0;
      bidx       <= '0;
      sh         <= '0;
      pbit       <= 1'b0;
      seen_hi    <= 1'b0;
      char_data  <= '0;
      char_valid <= 1'b0;
      hold_load  <= 1'b0;
      fifo_push  <= 1'b0;
      char_perr  <= 1'b0;
      char_ferr  <= 1'b0;
      char_brk   <= 1'b0;
    end else begin
      rx_d       <= rx_s;
      char_valid <= 1'b0;
      hold_load  <= 1'b0;
      fifo_push  <= 1'b0;
      unique case (st)
        S_IDLE:
          if (fall) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (tick16) begin
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              if (rx_s) st <= S_IDLE;
              else begin
                st      <= S_DATA;
                bidx    <= '0;
                seen_hi <= 1'b0;
              end
            end else cnt <= cnt + 1'b1;
          end
        S_DATA:
          if (tick16) begin
            cnt <= cnt + 1'b1;
            if (mid) begin
              sh      <= {rx_s, sh[7:1]};
              seen_hi <= seen_hi | rx_s;
              bidx    <= bidx + 1'b1;
              if (bidx == last_idx) st <= cfg_par_en ? S_PAR : S_STOP;
            end
          end
        S_PAR:
          if (tick16) begin
            cnt <= cnt + 1'b1;
            if (mid) begin
              pbit    <= rx_s;
              seen_hi <= seen_hi | rx_s;
              st      <= S_STOP;
            end
          end
        S_STOP:
          if (tick16) begin
            cnt <= cnt + 1'b1;
            if (mid) begin
              char_data  <= is_brk ? 8'h00 : data_al;
              char_perr  <= is_brk ? 1'b0 : par_bad;
              char_ferr  <= stop_low;
              char_brk   <= is_brk;
              char_valid <= 1'b1;
              hold_load  <= ~cfg_fifo_mode;
              fifo_push  <= cfg_fifo_mode;
              tcnt       <= '0;
              if (is_brk)                st <= S_BRKW;
              else if (tail_len == '0)   st <= S_IDLE;
              else                       st <= S_TAIL;
            end
          end
        S_TAIL:
          if (tick16) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == tail_len - 1'b1) st <= S_IDLE;
          end
        S_BRKW:
          if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
endmodule

module uart_rx_core_chk #(
  parameter int OVS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic [2:0] st,
  input logic [$clog2(OVS)-1:0] cnt,
  input logic       rx_s,
  input logic [7:0] char_data,
  input logic       char_valid,
  input logic       hold_load,
  input logic       fifo_push,
  input logic       char_ferr,
  input logic       char_brk
);
  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);
  // R7
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hold_load, fifo_push}));
  // R7
  route_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_load || fifo_push) |-> char_valid);
  // R6
  brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && char_brk) |-> (char_data == 8'h00 && char_ferr));
  // R6
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd6 && !rx_s) |=> (st == 3'd6 && !char_valid));
  // R5
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && tick16 && cnt == ($clog2(OVS))'(OVS/2 - 1) && rx_s) |=> st == 3'd0);
endmodule

bind uart_rx_core uart_rx_core_chk #(.OVS(OVS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .st(st), .cnt(cnt), .rx_s(rx_s),
  .char_data(char_data), .char_valid(char_valid), .hold_load(hold_load),
  .fifo_push(fifo_push), .char_ferr(char_ferr), .char_brk(char_brk)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
  localparam int BITC = 64;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1;
  logic [1:0] tdiv = '0;
  logic tick16;
  logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_fifo_mode = 1'b0;
  logic [7:0] char_data;
  logic char_valid, hold_load, fifo_push, char_perr, char_ferr, char_brk;

  int n_chk = 0, n_bad = 0, cap_cnt = 0, cap_hold = 0, cap_fifo = 0;
  logic [7:0] cap_data;
  logic cap_perr, cap_ferr, cap_brk;

  always #2 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd3);

  uart_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .cfg_fifo_mode(cfg_fifo_mode),
    .char_data(char_data), .char_valid(char_valid), .hold_load(hold_load),
    .fifo_push(fifo_push), .char_perr(char_perr), .char_ferr(char_ferr),
    .char_brk(char_brk));

  always @(negedge clk) begin
    if (char_valid) begin
      cap_cnt++;
      cap_data = char_data; cap_perr = char_perr;
      cap_ferr = char_ferr; cap_brk  = char_brk;
    end
    if (hold_load) cap_hold++;
    if (fifo_push) cap_fifo++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold_line(input bit v, input int clocks);
    @(negedge clk) rx_in = v;
    repeat (clocks - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pen,
                      input bit podd, input bit badp, input bit stop_v,
                      input int half_stops);
    bit p;
    p = podd;
    hold_line(1'b0, BITC);
    for (int i = 0; i < nb; i++) begin
      hold_line(d[i], BITC);
      p ^= d[i];
    end
    if (pen) hold_line(p ^ badp, BITC);
    hold_line(stop_v, BITC / 2 * half_stops);
    @(negedge clk) rx_in = 1'b1;
  endtask

  task automatic idle(input int bits);
    hold_line(1'b1, BITC * bits);
  endtask

  task automatic expect_char(input int base, input string req, input logic [7:0] d,
                             input bit pe, input bit fe, input bit bk);
    chk(cap_cnt == base + 1, req, "char count", cap_cnt, base + 1);
    chk(cap_data == d, req, "data", cap_data, d);
    chk(cap_perr == pe, req, "parity flag", cap_perr, pe);
    chk(cap_ferr == fe, req, "framing flag", cap_ferr, fe);
    chk(cap_brk == bk, req, "break flag", cap_brk, bk);
  endtask

  task automatic t_reset;
    chk(char_valid == 0 && hold_load == 0 && fifo_push == 0, "R9", "strobes", char_valid, 0);
    chk(char_data == 0 && char_perr == 0 && char_ferr == 0 && char_brk == 0,
        "R9", "data/flags", char_data, 0);
  endtask

  task automatic t_8n1;
    int b;
    cfg_len = 2'd3; cfg_par_en = 0; cfg_stop = 2'd0;
    b = cap_cnt; send(8'hA5, 8, 0, 0, 0, 1, 2); idle(2);
    expect_char(b, "R1", 8'hA5, 0, 0, 0);
    b = cap_cnt; send(8'h3C, 8, 0, 0, 0, 1, 2); idle(2);
    expect_char(b, "R1", 8'h3C, 0, 0, 0);
  endtask

  task automatic t_lengths;
    int b;
    cfg_len = 2'd0; b = cap_cnt; send(8'h15, 5, 0, 0, 0, 1, 2); idle(2);
    expect_char(b, "R2", 8'h15, 0, 0, 0);
    cfg_len = 2'd1; b = cap_cnt; send(8'h2B, 6, 0, 0, 0, 1, 2); idle(2);
    expect_char(b, "R2", 8'h2B, 0, 0, 0);
    cfg_len = 2'd2; b = cap_cnt; send(8'h5A, 7, 0, 0, 0, 1, 2); idle(2);
    expect_char(b, "R2", 8'h5A, 0, 0, 0);
    cfg_len = 2'd3;
  endtask

  task automatic t_parity;
    int b;
    cfg_par_en = 1;
    cfg_par_odd = 0; b = cap_cnt; send(8'h71, 8, 1, 0, 0, 1, 2); idle(2);
    expect_char(b, "R3", 8'h71, 0, 0, 0);
    cfg_par_odd = 1; b = cap_cnt; send(8'h71, 8, 1, 1, 0, 1, 2); idle(2);
    expect_char(b, "R3", 8'h71, 0, 0, 0);
    cfg_par_odd = 0; b = cap_cnt; send(8'h0F, 8, 1, 0, 1, 1, 2); idle(2);
    expect_char(b, "R3", 8'h0F, 1, 0, 0);
    cfg_par_odd = 1; b = cap_cnt; send(8'h80, 8, 1, 1, 1, 1, 2); idle(2);
    expect_char(b, "R3", 8'h80, 1, 0, 0);
    cfg_par_en = 0; cfg_par_odd = 0;
  endtask

  task automatic t_framing;
    int b;
    b = cap_cnt; send(8'h81, 8, 0, 0, 0, 0, 2); idle(2);
    expect_char(b, "R4", 8'h81, 0, 1, 0);
    b = cap_cnt; send(8'h42, 8, 0, 0, 0, 1, 2); idle(2);
    expect_char(b, "R4", 8'h42, 0, 0, 0);
  endtask

  task automatic t_false_start;
    int b;
    b = cap_cnt; hold_line(1'b0, 16); idle(12);
    chk(cap_cnt == b, "R5", "char after glitch", cap_cnt, b);
    b = cap_cnt; send(8'hC3, 8, 0, 0, 0, 1, 2); idle(2);
    expect_char(b, "R5", 8'hC3, 0, 0, 0);
  endtask

  task automatic t_break;
    int b;
    b = cap_cnt; hold_line(1'b0, BITC * 14);
    chk(cap_cnt == b + 1, "R6", "chars while low", cap_cnt, b + 1);
    chk(cap_data == 0 && cap_brk == 1 && cap_ferr == 1, "R6", "break char",
        {cap_brk, cap_ferr, cap_data}, 10'h300);
    idle(2);
    chk(cap_cnt == b + 1, "R6", "chars after release", cap_cnt, b + 1);
    b = cap_cnt; send(8'h96, 8, 0, 0, 0, 1, 2); idle(2);
    expect_char(b, "R6", 8'h96, 0, 0, 0);
  endtask

  task automatic t_route;
    int h, f;
    cfg_fifo_mode = 1; h = cap_hold; f = cap_fifo;
    send(8'h11, 8, 0, 0, 0, 1, 2); idle(2);
    chk(cap_fifo == f + 1 && cap_hold == h, "R7", "fifo route", cap_fifo - f, 1);
    cfg_fifo_mode = 0; h = cap_hold; f = cap_fifo;
    send(8'h22, 8, 0, 0, 0, 1, 2); idle(2);
    chk(cap_hold == h + 1 && cap_fifo == f, "R7", "hold route", cap_hold - h, 1);
  endtask

  task automatic t_stop;
    int b;
    cfg_stop = 2'd1; b = cap_cnt;
    send(8'h5C, 8, 0, 0, 0, 1, 3); send(8'hE7, 8, 0, 0, 0, 1, 3); idle(2);
    expect_char(b + 1, "R8", 8'hE7, 0, 0, 0);
    cfg_stop = 2'd2; b = cap_cnt;
    send(8'h55, 8, 0, 0, 0, 1, 2); hold_line(1'b0, 48); idle(12);
    chk(cap_cnt == b + 1, "R8", "edge in 2-stop tail", cap_cnt, b + 1);
    cfg_stop = 2'd0; b = cap_cnt;
    send(8'h55, 8, 0, 0, 0, 1, 2); hold_line(1'b0, 48); idle(12);
    chk(cap_cnt == b + 2, "R8", "edge after 1 stop", cap_cnt, b + 2);
    chk(cap_data == 8'hFF, "R8", "late start data", cap_data, 8'hFF);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_8n1;
    t_lengths;
    t_parity;
    t_framing;
    t_false_start;
    t_break;
    t_route;
    t_stop;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule